// File: doc/BRIEF.md
# Eight-Bit Timer/Counter with Compare Flags and Fast PWM

The block is an 8-bit up-counter. A clock prescaler advances it by one count per enabled tick. It has three ways of running. In free-running mode the counter wraps from 0xFF to 0x00. In clear-on-compare mode the ceiling is compare register A. In fast PWM mode the ceiling is either 0xFF or compare register A, and a second compare channel, B, shapes a single output pin. The block raises an overflow flag and a compare-A flag. Each flag stays set until it is cleared. An enable mask lets each flag drive its own interrupt request line.

Software programs the block through a write-only register port. The port carries the clock select and mode, the interrupt enables, both compare values and a write-one-to-clear flag register. In the PWM modes the compare-B value is staged and only takes effect at the end of a cycle, so one cycle never mixes two duty values. An interrupt controller can clear a flag directly with a one-cycle acknowledge pulse.

Top module: `tmr8_pwm`

## Requirements
- R1: On every tick at which the counter holds 0xFF (so that it rolls to 0x00), the overflow flag `flag_ovf` is set on that same clock edge.
- R2: The clock select field, bits [2:0] of the control register at address 0, picks the tick rate. Codes 1, 2, 3, 4 and 5 give one tick every 1, 8, 64, 256 and 1024 clocks. Codes 0, 6 and 7 stop the counter, which then holds its value.
- R3: The mode field is bits [4:3] of the control register. The codes are 0 free-running, 1 clear-on-compare, 2 fast PWM with ceiling 0xFF, and 3 fast PWM with ceiling compare A. The counter adds one per tick and returns to 0 on the tick after it holds the ceiling. The ceiling is 0xFF in modes 0 and 2 and compare A (address 2) in modes 1 and 3, so a ceiling of N gives a period of N+1 ticks.
- R4: The compare-A flag `flag_cmpa` is set on every tick at which the counter equals compare A. In modes 1 and 3 this is every return to 0.
- R5: Each interrupt line is high exactly while its flag is set and its enable bit is set. The enable register is at address 1: bit 0 gates overflow and bit 1 gates compare A.
- R6: A flag stays set until an acknowledge pulse (`ack_ovf`, `ack_cmpa`) or until a write to address 4 with a 1 in its bit (bit 0 overflow, bit 1 compare A). A new set event in the same cycle wins over the clear.
- R7: In modes 2 and 3, a write to compare B (address 3) is staged. The value in use is reloaded from the staged copy only on the tick at which the counter is at its ceiling. In modes 0 and 1 the staged value is used from the next clock.
- R8: In modes 2 and 3, `pwm_out` is high while the counter is between 0 and the active compare B value inclusive, and low for the rest of the cycle. With compare B at 0 the output is high for exactly one count per cycle. In modes 0 and 1 the output is low.
- R9: After reset the counter, compare registers, flags, enables and interrupt lines are zero and `pwm_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1 enables, 2 compare A, 3 compare B, 4 flag clear) |
| wr_data | input | 8 | Register write data |
| ack_ovf | input | 1 | Acknowledge pulse clearing the overflow flag |
| ack_cmpa | input | 1 | Acknowledge pulse clearing the compare-A flag |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cmpa | output | 1 | Compare-A interrupt request |
| flag_ovf | output | 1 | Overflow flag |
| flag_cmpa | output | 1 | Compare-A flag |
| cnt_value | output | 8 | Current counter value |
| pwm_out | output | 1 | PWM output pin |

## Verification
The hardest case to reach from the ports is a compare-B write that lands partway through a PWM cycle. The old value has to keep shaping the rest of that cycle, and the new value has to appear only after the ceiling. The bench waits on `cnt_value` until the counter reaches a chosen point inside the cycle and writes there. It then samples the output one count past the old threshold, in the current cycle and again in the next one. Mode changes leave the counter at an arbitrary value, so each scenario first waits for the counter to come back to 0 before it measures periods and high counts.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  localparam int CS_W   = 3;
  localparam int ADDR_W = 3;
  localparam int NFLAG  = 2;
  localparam int F_OVF  = 0;
  localparam int F_CMPA = 1;

  typedef enum logic [1:0] {
    MODE_FREE     = 2'd0,
    MODE_CTC      = 2'd1,
    MODE_PWM_FULL = 2'd2,
    MODE_PWM_A    = 2'd3
  } tmr_mode_e;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_IEN  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMPA = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMPB = 3'd3;
  localparam logic [ADDR_W-1:0] A_FCLR = 3'd4;
endpackage

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler
  import tmr8_pkg::*;
#(
  parameter int PSC_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CS_W-1:0] sel,
  output logic            tick
);
  logic [PSC_W-1:0] pcnt_q, pcnt_d, mask;
  logic             running;

  always_comb begin
    running = (sel != '0) && (sel <= CS_W'(5));
    case (sel)
      CS_W'(2): mask = PSC_W'(7);
      CS_W'(3): mask = PSC_W'(63);
      CS_W'(4): mask = PSC_W'(255);
      CS_W'(5): mask = PSC_W'(1023);
      default:  mask = '0;
    endcase
    pcnt_d = running ? pcnt_q + 1'b1 : '0;
    tick   = running && ((pcnt_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end
endmodule

// File: rtl/tmr8_regs.sv
module tmr8_regs
  import tmr8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CS_W-1:0]   sel,
  output tmr_mode_e         mode,
  output logic [NFLAG-1:0]  ien,
  output logic [CNT_W-1:0]  cmpa,
  output logic [CNT_W-1:0]  cmpb_buf,
  output logic [NFLAG-1:0]  fclr
);
  logic [CS_W-1:0]  sel_d;
  tmr_mode_e        mode_d;
  logic [NFLAG-1:0] ien_d;
  logic [CNT_W-1:0] cmpa_d, cmpb_d;

  always_comb begin
    sel_d  = sel;
    mode_d = mode;
    ien_d  = ien;
    cmpa_d = cmpa;
    cmpb_d = cmpb_buf;
    fclr   = '0;
    if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          sel_d  = wr_data[CS_W-1:0];
          mode_d = tmr_mode_e'(wr_data[CS_W+1:CS_W]);
        end
        A_IEN:   ien_d  = wr_data[NFLAG-1:0];
        A_CMPA:  cmpa_d = wr_data;
        A_CMPB:  cmpb_d = wr_data;
        A_FCLR:  fclr   = wr_data[NFLAG-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel      <= '0;
      mode     <= MODE_FREE;
      ien      <= '0;
      cmpa     <= '0;
      cmpb_buf <= '0;
    end else begin
      sel      <= sel_d;
      mode     <= mode_d;
      ien      <= ien_d;
      cmpa     <= cmpa_d;
      cmpb_buf <= cmpb_d;
    end
  end
endmodule

// File: rtl/tmr8_core.sv
module tmr8_core
  import tmr8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  tmr_mode_e        mode,
  input  logic [CNT_W-1:0] cmpa,
  input  logic [CNT_W-1:0] cmpb_buf,
  input  logic [NFLAG-1:0] ack,
  input  logic [NFLAG-1:0] fclr,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] top_val,
  output logic [CNT_W-1:0] cmpb_act,
  output logic [NFLAG-1:0] flags,
  output logic             pwm
);
  logic [CNT_W-1:0] cnt_d, cmpb_act_d;
  logic [NFLAG-1:0] flags_d, set_ev;
  logic             pwm_d, pwm_mode, at_top, wrap;

  always_comb begin
    pwm_mode = mode[1];
    top_val  = mode[0] ? cmpa : '1;
    at_top   = (cnt == top_val);
    wrap     = tick && at_top;
    cnt_d    = tick ? (at_top ? '0 : cnt + 1'b1) : cnt;

    set_ev[F_OVF]  = tick && (cnt == '1);
    set_ev[F_CMPA] = tick && (cnt == cmpa);
    flags_d = set_ev | (flags & ~ack & ~fclr);

    if (!pwm_mode)  cmpb_act_d = cmpb_buf;
    else if (wrap)  cmpb_act_d = cmpb_buf;
    else            cmpb_act_d = cmpb_act;

    if (!pwm_mode)                     pwm_d = 1'b0;
    else if (wrap)                     pwm_d = 1'b1;
    else if (tick && cnt == cmpb_act)  pwm_d = 1'b0;
    else                               pwm_d = pwm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      cmpb_act <= '0;
      flags    <= '0;
      pwm      <= 1'b0;
    end else begin
      cnt      <= cnt_d;
      cmpb_act <= cmpb_act_d;
      flags    <= flags_d;
      pwm      <= pwm_d;
    end
  end
endmodule

// File: rtl/tmr8_pwm.sv
module tmr8_pwm
  import tmr8_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PSC_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              ack_ovf,
  input  logic              ack_cmpa,
  output logic              irq_ovf,
  output logic              irq_cmpa,
  output logic              flag_ovf,
  output logic              flag_cmpa,
  output logic [CNT_W-1:0]  cnt_value,
  output logic              pwm_out
);
  logic [CS_W-1:0]  sel;
  tmr_mode_e        mode;
  logic [NFLAG-1:0] ien, fclr, ack, flags, irq;
  logic [CNT_W-1:0] cmpa, cmpb_buf, cmpb_act, cnt, top_val;
  logic             tick, pwm, pwm_mode;

  tmr8_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sel(sel), .mode(mode), .ien(ien), .cmpa(cmpa),
    .cmpb_buf(cmpb_buf), .fclr(fclr)
  );

  tmr8_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .sel(sel), .tick(tick)
  );

  tmr8_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .cmpa(cmpa),
    .cmpb_buf(cmpb_buf), .ack(ack), .fclr(fclr), .cnt(cnt),
    .top_val(top_val), .cmpb_act(cmpb_act), .flags(flags), .pwm(pwm)
  );

  always_comb begin
    ack[F_OVF]  = ack_ovf;
    ack[F_CMPA] = ack_cmpa;
    pwm_mode    = mode[1];
    irq         = flags & ien;
    irq_ovf     = irq[F_OVF];
    irq_cmpa    = irq[F_CMPA];
    flag_ovf    = flags[F_OVF];
    flag_cmpa   = flags[F_CMPA];
    cnt_value   = cnt;
    pwm_out     = pwm;
  end
endmodule

// File: rtl/tmr8_pwm_chk.sv
module tmr8_pwm_chk
  import tmr8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [CS_W-1:0]  sel,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] top_val,
  input logic [CNT_W-1:0] cmpb_act,
  input logic             pwm_mode,
  input logic [NFLAG-1:0] flags,
  input logic [NFLAG-1:0] ack,
  input logic [NFLAG-1:0] fclr,
  input logic [NFLAG-1:0] ien,
  input logic [NFLAG-1:0] irq,
  input logic             pwm
);
  a_r2_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '0 || sel > CS_W'(5)) |=> $stable(cnt));

  a_r3_no_tick_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == top_val) |=> (cnt == '0));

  a_r1_overflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == '1) |=> flags[F_OVF]);

  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[F_OVF] && !ack[F_OVF] && !fclr[F_OVF]) |=> flags[F_OVF]);

  a_r6_cmpa_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[F_CMPA] && !ack[F_CMPA] && !fclr[F_CMPA]) |=> flags[F_CMPA]);

  a_r5_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> (irq == '0));

  a_r7_cmpb_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && !(tick && cnt == top_val)) |=> $stable(cmpb_act));

  a_r8_low_outside_pwm: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_mode |=> !pwm);
endmodule

bind tmr8_pwm tmr8_pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .sel(sel), .cnt(cnt),
  .top_val(top_val), .cmpb_act(cmpb_act), .pwm_mode(pwm_mode),
  .flags(flags), .ack(ack), .fclr(fclr), .ien(ien), .irq({irq_cmpa, irq_ovf}),
  .pwm(pwm)
);

// File: tb/tmr8_pwm_tb.sv
module tmr8_pwm_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       ack_ovf = 1'b0;
  logic       ack_cmpa = 1'b0;
  logic       irq_ovf, irq_cmpa, flag_ovf, flag_cmpa, pwm_out;
  logic [7:0] cnt_value;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  tmr8_pwm u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ack_ovf(ack_ovf), .ack_cmpa(ack_cmpa),
    .irq_ovf(irq_ovf), .irq_cmpa(irq_cmpa), .flag_ovf(flag_ovf),
    .flag_cmpa(flag_cmpa), .cnt_value(cnt_value), .pwm_out(pwm_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cnt(input logic [7:0] v, input int limit);
    for (int i = 0; i < limit; i++) begin
      step();
      if (cnt_value == v) return;
    end
  endtask

  function automatic logic [7:0] ctrl(input int mode, input int sel);
    return 8'((mode << 3) | sel);
  endfunction

  task automatic t_reset();
    check("R9 counter", int'(cnt_value), 0);
    check("R9 pwm", int'(pwm_out), 0);
    check("R9 irq", int'({irq_cmpa, irq_ovf}), 0);
    check("R9 flags", int'({flag_cmpa, flag_ovf}), 0);
  endtask

  task automatic t_stopped();
    repeat (20) step();
    check("R2 select 0 stops", int'(cnt_value), 0);
    wr(3'd0, ctrl(0, 6));
    repeat (20) step();
    check("R2 select 6 stops", int'(cnt_value), 0);
  endtask

  task automatic t_free_run();
    logic [7:0] a;
    wr(3'd0, ctrl(0, 1));
    a = cnt_value;
    step();
    check("R3 increments per clock", int'(cnt_value), int'(a + 8'd1));
    wait_cnt(8'hFF, 300);
    step();
    check("R3 free wrap to 0", int'(cnt_value), 0);
    check("R1 overflow flag", int'(flag_ovf), 1);
    check("R5 masked irq", int'(irq_ovf), 0);
    wr(3'd1, 8'd1);
    check("R5 enabled irq", int'(irq_ovf), 1);
    @(negedge clk); ack_ovf = 1'b1;
    @(negedge clk); ack_ovf = 1'b0;
    check("R6 ack clears", int'(flag_ovf), 0);
    check("R5 irq drops", int'(irq_ovf), 0);
    wait_cnt(8'hFF, 300);
    step();
    check("R1 second overflow", int'(flag_ovf), 1);
    wr(3'd4, 8'd1);
    check("R6 write-one clears", int'(flag_ovf), 0);
    wr(3'd1, 8'd0);
  endtask

  task automatic t_prescale(input int sel, input int ratio);
    logic [7:0] prev;
    int n;
    wr(3'd0, ctrl(0, sel));
    prev = cnt_value;
    for (int i = 0; i < 2 * ratio + 4; i++) begin
      step();
      if (cnt_value != prev) break;
    end
    prev = cnt_value;
    n = 0;
    for (int i = 0; i < 2 * ratio + 4; i++) begin
      step(); n++;
      if (cnt_value != prev) break;
    end
    check($sformatf("R2 ratio select %0d", sel), n, ratio);
  endtask

  task automatic t_ctc();
    int n;
    wr(3'd2, 8'd9);
    wr(3'd0, ctrl(1, 1));
    wait_cnt(8'd9, 300);
    step();
    wr(3'd4, 8'd3);
    wait_cnt(8'd9, 20);
    step();
    check("R3 ctc returns to 0", int'(cnt_value), 0);
    check("R4 compare flag on reset", int'(flag_cmpa), 1);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      step(); n++;
      if (cnt_value == 8'd0) break;
    end
    check("R3 ctc period", n, 10);
    check("R1 no overflow in ctc", int'(flag_ovf), 0);
    wr(3'd1, 8'd2);
    check("R5 cmpa irq", int'(irq_cmpa), 1);
    check("R5 ovf irq masked", int'(irq_ovf), 0);
    wr(3'd1, 8'd0);
  endtask

  task automatic t_pwm_full();
    int bad, highs;
    wr(3'd3, 8'h40);
    wr(3'd0, ctrl(2, 1));
    wait_cnt(8'd0, 300);
    bad = 0; highs = 0;
    for (int i = 0; i < 256; i++) begin
      if (pwm_out != (cnt_value <= 8'h40)) bad++;
      highs += int'(pwm_out);
      step();
    end
    check("R8 pwm shape mismatches", bad, 0);
    check("R8 pwm high counts", highs, 65);
  endtask

  task automatic t_buffer();
    wait_cnt(8'h10, 300);
    wr(3'd3, 8'h80);
    wait_cnt(8'h41, 300);
    check("R7 old value kept this cycle", int'(pwm_out), 0);
    wait_cnt(8'h41, 300);
    check("R7 new value next cycle high", int'(pwm_out), 1);
    wait_cnt(8'h81, 300);
    check("R7 new value next cycle low", int'(pwm_out), 0);
  endtask

  task automatic t_zero_duty();
    int highs;
    wr(3'd3, 8'h00);
    wait_cnt(8'd0, 300);
    wait_cnt(8'd0, 300);
    highs = 0;
    for (int i = 0; i < 256; i++) begin
      highs += int'(pwm_out);
      step();
    end
    check("R8 zero compare one count high", highs, 1);
  endtask

  task automatic t_pwm_top_a();
    int n, highs;
    wr(3'd2, 8'h1F);
    wr(3'd3, 8'h0F);
    wr(3'd0, ctrl(3, 1));
    wait_cnt(8'd0, 300);
    wr(3'd4, 8'd3);
    wait_cnt(8'd0, 40);
    check("R4 flag on pwm reset", int'(flag_cmpa), 1);
    n = 0; highs = 0;
    for (int i = 0; i < 40; i++) begin
      highs += int'(pwm_out);
      step(); n++;
      if (cnt_value == 8'd0) break;
    end
    check("R3 pwm ceiling A period", n, 32);
    check("R8 pwm ceiling A high counts", highs, 16);
  endtask

  task automatic t_leave_pwm();
    wr(3'd0, ctrl(0, 1));
    step();
    check("R8 low outside pwm", int'(pwm_out), 0);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_stopped();
    t_free_run();
    t_prescale(2, 8);
    t_prescale(3, 64);
    t_prescale(4, 256);
    t_prescale(5, 1024);
    t_ctc();
    t_pwm_full();
    t_buffer();
    t_zero_duty();
    t_pwm_top_a();
    t_leave_pwm();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule